// File: doc/BRIEF.md
# Bidirectional Byte-Flagged Mailbox with Doorbell Interrupts

This block exchanges small items of command, status or parameter data between two independent agents, a host side and a local side. Each direction owns four 32-bit mailboxes: the host writes the four host-to-local mailboxes and the local side reads them, and the reverse holds for the four local-to-host mailboxes. Every mailbox byte has its own full flag. A write sets the flag of each enabled byte, and a read by the receiving side clears it. An 8-, 16- or 32-bit agent can therefore pass single bytes without packing whole words. Both sides can poll all 32 flags in one status word.

Each side has a doorbell configuration word. It names one mailbox byte by its status-bit index and fires either when that byte goes from empty to full or whenever it is accessed. It then raises a level interrupt on the host side or on the local side. The interrupt stays high until the receiving side writes 1 to its interrupt status bit. A strobe pin also loads an 8-bit pin value straight into one dedicated local-to-host byte. That load can interrupt the host, and the byte's contents are always visible on an output pin bus.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, all 32 flags are empty, all mailbox data, configuration and interrupt status read as zero, and `h_irq`, `l_irq` and `pin_q` are low.
- R2: Both sides share one byte address map: 00h/04h/08h/0Ch are host-to-local mailboxes 0..3, 10h/14h/18h/1Ch are local-to-host mailboxes 0..3, 34h is status, 38h is the side's doorbell configuration and 3Ch is the side's interrupt status. Reads return the full word combinationally.
- R3: A host write to a host-to-local mailbox updates only the bytes whose enable is set and sets their flags. Status bit 4n+b (bits 15:0) is byte b of host-to-local mailbox n.
- R4: A local write to a local-to-host mailbox updates only the enabled bytes and sets their flags. Status bit 16+4n+b is byte b of local-to-host mailbox n.
- R5: A read by the receiving side clears the flags of the enabled bytes only. Reading status, or reading a mailbox the side itself sends, changes no flag.
- R6: A side writing a mailbox it receives has no effect on data or flags.
- R7: If one side writes a byte in the same cycle that the other side reads it, the byte ends full and holds the new data.
- R8: Configuration word: bit0 enable, bit1 mode (0 = fill, 1 = touch), bit2 route (0 = host, 1 = local), bits 7:3 target status-bit index, bit8 (host word) enables the pin-load interrupt. In fill mode the doorbell fires only when the target byte is written while empty.
- R9: In touch mode any effective read or write of the target byte fires the doorbell. A disabled configuration never fires.
- R10: Interrupt status bit0 (doorbell) and host bit1 (pin load) drive the side's interrupt level. They stay set until 1 is written to that bit at 3Ch. Writing 0 leaves them set.
- R11: A `pin_ld` pulse writes `pin_d` into byte 3 of local-to-host mailbox 3 and sets status bit 31. `pin_q` shows that byte one cycle later. If host configuration bit8 is set, the pulse also sets host interrupt status bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_en | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 6 | Host byte address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| h_irq | output | 1 | Host interrupt level |
| l_en | input | 1 | Local access strobe |
| l_we | input | 1 | Local write (1) or read (0) |
| l_addr | input | 6 | Local byte address |
| l_be | input | 4 | Local byte enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data |
| l_irq | output | 1 | Local interrupt level |
| pin_ld | input | 1 | Direct byte load strobe |
| pin_d | input | 8 | Direct byte load data |
| pin_q | output | 8 | Direct byte contents |

## Verification
The bench targets a write and an opposing read of the same byte in one cycle. A design that let the read win would leave that byte empty, and the next read would return stale data. It writes a doorbell target that is already full and expects no interrupt, because a design that fires on every write would ring again. It writes 0 to the interrupt status and expects the line to stay high, which catches a plain-write acknowledge. It also checks that a partial byte-enable read clears only its own flags, that a write into the receiving mailbox is dropped, and that a pin load lands in status bit 31 and in `pin_q`.

// File: rtl/mbox_bridge.sv
module mbox_bridge #(
  parameter int unsigned CFG_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_en,
  input  logic        h_we,
  input  logic [5:0]  h_addr,
  input  logic [3:0]  h_be,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        h_irq,
  input  logic        l_en,
  input  logic        l_we,
  input  logic [5:0]  l_addr,
  input  logic [3:0]  l_be,
  input  logic [31:0] l_wdata,
  output logic [31:0] l_rdata,
  output logic        l_irq,
  input  logic        pin_ld,
  input  logic [7:0]  pin_d,
  output logic [7:0]  pin_q
);
  localparam logic [5:0] A_STAT = 6'h34;
  localparam logic [5:0] A_CFG  = 6'h38;
  localparam logic [5:0] A_IST  = 6'h3C;
  localparam int unsigned PIN_BIT = 31;

  logic [31:0] mb [8];
  logic [31:0] full;
  logic [31:0] wr_v, rd_v;
  logic [CFG_W-1:0] cfg_h, cfg_l;
  logic [1:0] ist_h;
  logic       ist_l;

  wire h_mb   = h_en && !h_addr[5];
  wire l_mb   = l_en && !l_addr[5];
  wire h_wok  = h_mb && h_we && !h_addr[4];
  wire h_rclr = h_mb && !h_we && h_addr[4];
  wire l_wok  = l_mb && l_we && l_addr[4];
  wire l_rclr = l_mb && !l_we && !l_addr[4];

  always_comb begin
    wr_v = '0;
    rd_v = '0;
    for (int b = 0; b < 4; b++) begin
      if (h_be[b] && h_wok)  wr_v[{h_addr[4:2], 2'(b)}] = 1'b1;
      if (h_be[b] && h_rclr) rd_v[{h_addr[4:2], 2'(b)}] = 1'b1;
      if (l_be[b] && l_wok)  wr_v[{l_addr[4:2], 2'(b)}] = 1'b1;
      if (l_be[b] && l_rclr) rd_v[{l_addr[4:2], 2'(b)}] = 1'b1;
    end
    if (pin_ld) wr_v[PIN_BIT] = 1'b1;
  end

  wire [31:0] tch = wr_v | rd_v;

  function automatic logic ring(input logic [CFG_W-1:0] c, input logic [31:0] w,
                                input logic [31:0] t, input logic [31:0] f);
    return c[0] && (c[1] ? t[c[7:3]] : (w[c[7:3]] && !f[c[7:3]]));
  endfunction

  wire db_h = ring(cfg_h, wr_v, tch, full);
  wire db_l = ring(cfg_l, wr_v, tch, full);
  wire ev_h = (db_h && !cfg_h[2]) || (db_l && !cfg_l[2]);
  wire ev_l = (db_h && cfg_h[2]) || (db_l && cfg_l[2]);
  wire h_ack = h_en && h_we && (h_addr == A_IST);
  wire l_ack = l_en && l_we && (l_addr == A_IST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mb[i] <= '0;
      full  <= '0;
      cfg_h <= '0;
      cfg_l <= '0;
      ist_h <= '0;
      ist_l <= 1'b0;
    end else begin
      full <= (full & ~rd_v) | wr_v;
      for (int i = 0; i < 8; i++)
        for (int b = 0; b < 4; b++)
          if (wr_v[i*4+b]) begin
            if (i == 7 && b == 3 && pin_ld) mb[i][b*8 +: 8] <= pin_d;
            else if (i < 4)                 mb[i][b*8 +: 8] <= h_wdata[b*8 +: 8];
            else                            mb[i][b*8 +: 8] <= l_wdata[b*8 +: 8];
          end
      if (h_en && h_we && h_addr == A_CFG) cfg_h <= h_wdata[CFG_W-1:0];
      if (l_en && l_we && l_addr == A_CFG) cfg_l <= l_wdata[CFG_W-1:0];
      ist_h[0] <= ev_h || (ist_h[0] && !(h_ack && h_wdata[0]));
      ist_h[1] <= (pin_ld && cfg_h[8]) || (ist_h[1] && !(h_ack && h_wdata[1]));
      ist_l    <= ev_l || (ist_l && !(l_ack && l_wdata[0]));
    end
  end

  function automatic logic [31:0] rmux(input logic [5:0] a, input logic [CFG_W-1:0] c,
                                       input logic [1:0] s);
    if (!a[5]) return mb[a[4:2]];
    case (a)
      A_STAT:  return full;
      A_CFG:   return 32'(c);
      A_IST:   return {30'b0, s};
      default: return '0;
    endcase
  endfunction

  assign h_rdata = rmux(h_addr, cfg_h, ist_h);
  assign l_rdata = rmux(l_addr, cfg_l, {1'b0, ist_l});
  assign h_irq   = |ist_h;
  assign l_irq   = ist_l;
  assign pin_q   = mb[7][31:24];

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (full == '0) && !h_irq && !l_irq && (pin_q == 8'h00));

  a_r6_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_we && !l_addr[5] && !l_addr[4] && !h_en && !pin_ld) |=> $stable(full[15:0]));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en && h_we && h_addr == 6'h00 && h_be[0] && l_en && !l_we && l_addr == 6'h00)
      |=> full[0] && (mb[0][7:0] == $past(h_wdata[7:0])));

  a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (l_irq && !(l_en && l_we && l_addr == A_IST && l_wdata[0])) |=> l_irq);

  a_r11_pin_load: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ld |=> (pin_q == $past(pin_d)) && full[PIN_BIT]);
endmodule

// File: tb/mbox_bridge_bench.sv
module mbox_bridge_bench;
  logic clk = 0, rst_n = 0;
  logic h_en = 0, h_we = 0, l_en = 0, l_we = 0, pin_ld = 0;
  logic [5:0] h_addr = 0, l_addr = 0;
  logic [3:0] h_be = 0, l_be = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic [31:0] h_rdata, l_rdata;
  logic h_irq, l_irq;
  logic [7:0] pin_d = 0, pin_q;
  int checks = 0, errors = 0;
  logic [31:0] hr, lr;

  always #4 clk = ~clk;

  mbox_bridge u_mbox_bridge (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hset(logic we, logic [5:0] a, logic [3:0] be, logic [31:0] d);
    h_en = 1; h_we = we; h_addr = a; h_be = be; h_wdata = d;
  endtask
  task automatic lset(logic we, logic [5:0] a, logic [3:0] be, logic [31:0] d);
    l_en = 1; l_we = we; l_addr = a; l_be = be; l_wdata = d;
  endtask
  task automatic step();
    #1; hr = h_rdata; lr = l_rdata;
    @(posedge clk); #1;
    h_en = 0; l_en = 0; pin_ld = 0;
  endtask

  // {op[1:0] (0 hW,1 lW,2 hR,3 lR), addr[5:0], be[3:0], data[31:0], exp[31:0]}
  localparam logic [75:0] VEC [13] = '{
    {2'd0, 6'h00, 4'b0011, 32'hA1B2C3D4, 32'h0},
    {2'd3, 6'h34, 4'b0000, 32'h0, 32'h00000003},
    {2'd3, 6'h00, 4'b0001, 32'h0, 32'h0000C3D4},
    {2'd3, 6'h34, 4'b0000, 32'h0, 32'h00000002},
    {2'd1, 6'h1C, 4'b1100, 32'h11223344, 32'h0},
    {2'd2, 6'h34, 4'b0000, 32'h0, 32'hC0000002},
    {2'd2, 6'h1C, 4'b1000, 32'h0, 32'h11220000},
    {2'd2, 6'h34, 4'b0000, 32'h0, 32'h40000002},
    {2'd1, 6'h00, 4'b1111, 32'hFFFFFFFF, 32'h0},
    {2'd3, 6'h00, 4'b0000, 32'h0, 32'h0000C3D4},
    {2'd3, 6'h34, 4'b0000, 32'h0, 32'h40000002},
    {2'd0, 6'h04, 4'b0100, 32'h00AB0000, 32'h0},
    {2'd2, 6'h34, 4'b0000, 32'h0, 32'h40000042}
  };

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq", {30'b0, h_irq, l_irq}, 32'h0);
    chk("R1 pin_q", {24'b0, pin_q}, 32'h0);
    #2 rst_n = 1;
    @(posedge clk); #1;
    hset(0, 6'h34, 0, 0); lset(0, 6'h38, 0, 0); step();
    chk("R1 status", hr, 32'h0);
    chk("R1 cfg", lr, 32'h0);

    // R2 R3 R4 R5 R6 vector walk
    for (int i = 0; i < 13; i++) begin
      logic [75:0] v;
      v = VEC[i];
      case (v[75:74])
        2'd0: hset(1, v[73:68], v[67:64], v[63:32]);
        2'd1: lset(1, v[73:68], v[67:64], v[63:32]);
        2'd2: hset(0, v[73:68], v[67:64], 0);
        default: lset(0, v[73:68], v[67:64], 0);
      endcase
      step();
      if (v[75:74] == 2'd2) chk($sformatf("R2-R5 vec%0d", i), hr, v[31:0]);
      if (v[75:74] == 2'd3) chk($sformatf("R3/R5/R6 vec%0d", i), lr, v[31:0]);
    end

    // R7 same-cycle write and read
    hset(1, 6'h08, 4'b0001, 32'h01); step();
    hset(1, 6'h08, 4'b0001, 32'h5A); lset(0, 6'h08, 4'b0001, 0); step();
    hset(0, 6'h34, 0, 0); step();
    chk("R7 flag", hr & 32'h100, 32'h100);
    lset(0, 6'h08, 4'b0001, 0); step();
    chk("R7 data", lr & 32'hFF, 32'h5A);

    // R8 fill mode, route host
    lset(1, 6'h38, 4'hF, 32'h41); step();
    hset(1, 6'h08, 4'b0001, 32'h77); step();
    chk("R8 fill fires", {31'b0, h_irq}, 1);
    // R10 write 0 keeps, write 1 clears
    hset(1, 6'h3C, 4'hF, 32'h0); step();
    chk("R10 hold", {31'b0, h_irq}, 1);
    hset(1, 6'h3C, 4'hF, 32'h1); step();
    chk("R10 clear", {31'b0, h_irq}, 0);
    hset(1, 6'h08, 4'b0001, 32'h78); step();
    chk("R8 already full", {31'b0, h_irq}, 0);

    // R9 touch mode routed to local
    hset(1, 6'h38, 4'hF, 32'h47); step();
    lset(0, 6'h08, 4'b0001, 0); step();
    chk("R9 touch local", {31'b0, l_irq}, 1);
    chk("R9 no host", {31'b0, h_irq}, 0);
    lset(1, 6'h3C, 4'hF, 32'h1); step();
    chk("R10 local clear", {31'b0, l_irq}, 0);

    // R9 disabled
    hset(1, 6'h38, 4'hF, 0); lset(1, 6'h38, 4'hF, 0); step();
    lset(0, 6'h08, 4'b0001, 0); step();
    hset(1, 6'h08, 4'b0001, 32'h99); step();
    chk("R9 disabled", {30'b0, h_irq, l_irq}, 0);

    // R11 pin load
    hset(1, 6'h38, 4'hF, 32'h100); step();
    pin_d = 8'h9C; pin_ld = 1; step();
    chk("R11 pin_q", {24'b0, pin_q}, 32'h9C);
    chk("R11 irq", {31'b0, h_irq}, 1);
    hset(0, 6'h3C, 0, 0); step();
    chk("R11 ist", hr, 32'h2);
    hset(0, 6'h34, 0, 0); step();
    chk("R11 flag", hr & 32'h80000000, 32'h80000000);
    hset(0, 6'h1C, 4'b1000, 0); step();
    chk("R11 data", hr, 32'h9C220000);
    hset(1, 6'h3C, 4'hF, 32'h2); step();
    chk("R11 ack", {31'b0, h_irq}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule